// File: doc/BRIEF.md
# Shared Interrupt / Power-Down Pin Controller

This block owns one bidirectional pad that does double duty. Out of reset the pad is an input: the board holds it high with a pull-up, and driving it low asks the chip to power down. Software can turn the same pad into an interrupt output instead. When it does, the block drives the pad whenever an enabled event is waiting to be serviced. The level it drives in that case is set by a polarity bit.

A small register port exposes three registers. The configuration register at 0x11 holds the output-mode bit (bit 0), the interrupt-enable bit (bit 1) and the polarity bit (bit 2). Two event registers sit at 0x12 and 0x13. Each one carries eight per-source enables in bits 7:0 and eight latched status flags in bits 15:8. Event pulses from sixteen sources set the status flags. When software reads either event register, the pending flags in both registers are cleared.

The pad itself and the logic that produces the event pulses live elsewhere. This block only produces the output-enable and the output data for the pad, and it receives the pad's input value.

Top module: `irq_pdn_pin_ctrl`

## Requirements
- R1: After reset, every register reads 0x0000, `pin_oe` is 0 and `pdn_req` is 0 while `pin_in` is high.
- R2: `pin_oe` equals bit 0 of register 0x11 from the cycle after that register is written.
- R3: Writing 0x11 stores bits 2:0 only. A read of 0x11 returns those three bits and zero everywhere else. Addresses other than 0x11–0x13 read as zero.
- R4: While bit 0 of 0x11 is 0, `pdn_req` equals the inverse of `pin_in` as seen two clock edges earlier. While bit 0 is 1, `pdn_req` is 0 whatever the pin does.
- R5: An event pulse on source k sets status bit 8+(k mod 8) of register 0x12+(k div 8). The new value is visible on the next cycle.
- R6: A write to 0x12 or 0x13 updates only the enable bits 7:0. The data on bits 15:8 has no effect on the status flags.
- R7: With output mode and interrupt enable both set, the pad is driven to its asserted level in the same cycle that an enabled event pulse arrives. It stays asserted while that event is pending.
- R8: Events whose source enable is 0, or that arrive while the interrupt-enable bit is 0, still set their status flags but leave the pad at its idle level.
- R9: With polarity 0 the asserted level is 0 and the idle level is 1. With polarity 1 both levels are inverted.
- R10: While `reg_rd_en` is high, a read of 0x12 or 0x13 returns the current contents, and from the next cycle every status flag in both registers is 0.
- R11: An event that arrives in the same cycle as a clearing read is pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Register address |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 16 | Write data |
| reg_rd_en | input | 1 | Read strobe; on an event register it clears all status |
| reg_rd_data | output | 16 | Read data, combinational from `reg_addr` |
| evt_pulse | input | 16 | One-cycle event pulses, source k on bit k |
| pin_in | input | 1 | Value sensed at the pad |
| pin_oe | output | 1 | Pad output enable |
| pin_out | output | 1 | Pad output value |
| pdn_req | output | 1 | Power-down request |

## Verification
The results of this block fall due at three different depths:
- **Same cycle:** the pad drive and the read data depend only on inputs and current state, so they must be correct in the same cycle as the stimulus.
- **Next cycle:** writes, status setting and clears show up one cycle later.
- **Two edges:** `pdn_req` follows the pin two edges later.

The bench drives inputs just after the falling edge and compares every output against a behavioural model shortly afterwards. It then advances the model at the rising edge, so each result is checked in exactly the cycle it is due. Directed checks target the same-cycle event-plus-clear case, masked events and both polarities. A stretch of pseudo-random traffic follows them.

// File: rtl/ipc_pkg.sv
// Package: shared constants and the configuration record for the
// interrupt / power-down pin controller.
// Assumes: register map fixed at 0x11 (config) and 0x12 upward (event banks).
package ipc_pkg;

    localparam int unsigned CFG_ADDR  = 32'h11;
    localparam int unsigned BANK_BASE = 32'h12;

    // Configuration fields, bit 0 = mode, bit 1 = irq enable, bit 2 = polarity
    typedef struct packed {
        logic pol;
        logic ien;
        logic mode;
    } ipc_cfg_t;

    localparam int unsigned CFG_W = $bits(ipc_cfg_t);

endpackage

// File: rtl/ipc_cfg_reg.sv
// Module: ipc_cfg_reg
// Holds the pin configuration record (mode, interrupt enable, polarity).
// Assumes: wr_sel is already qualified by address decode and write strobe.
module ipc_cfg_reg
    import ipc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_sel,
    input  ipc_cfg_t wr_cfg,
    output ipc_cfg_t cfg
);

    // Load configuration on a selected write, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_sel) begin
            cfg <= wr_cfg;
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(cfg)); // R3

endmodule

// File: rtl/ipc_event_bank.sv
// Module: ipc_event_bank
// One event register: per-source enables and latched status flags.
// A clearing read empties the flags; an event in the same cycle wins.
// Assumes: evt is a set of one-cycle pulses synchronous to clk.
module ipc_event_bank #(
    parameter int unsigned NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_sel,
    input  logic [NSRC-1:0] wr_en_bits,
    input  logic            clr,
    input  logic [NSRC-1:0] evt,
    output logic [NSRC-1:0] en,
    output logic [NSRC-1:0] st,
    output logic            hit
);

    logic [NSRC-1:0] st_next;

    // Next status: keep or clear, then merge incoming events
    always_comb begin
        st_next = (clr ? '0 : st) | evt;
    end

    // Status flag register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else begin
            st <= st_next;
        end
    end

    // Enable register, written only through the enable field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= '0;
        end else if (wr_sel) begin
            en <= wr_en_bits;
        end
    end

    // Enabled-pending flag including same-cycle events (no clock delay)
    always_comb begin
        hit = |((st | evt) & en);
    end

    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((st & $past(evt)) == $past(evt))); // R5

    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (evt == '0)) |=> (st == '0)); // R10

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(en)); // R6

    AST_ST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (evt == '0)) |=> $stable(st)); // R6

endmodule

// File: rtl/ipc_pin_drive.sv
// Module: ipc_pin_drive
// Produces pad output enable and data, and the power-down request from the
// synchronised pad input.
// Assumes: pin_in is asynchronous; its idle (pulled-up) level is 1.
module ipc_pin_drive
    import ipc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  ipc_cfg_t cfg,
    input  logic     any_hit,
    input  logic     pin_in,
    output logic     pin_oe,
    output logic     pin_out,
    output logic     pdn_req
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   irq_active;

    // Synchronise the pad input, resetting to the pulled-up level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
        end
    end

    // Interrupt is signalled only in output mode with enable set
    always_comb begin
        irq_active = cfg.mode & cfg.ien & any_hit;
    end

    // Pad drive: asserted level equals the polarity bit, idle is its inverse
    always_comb begin
        pin_oe  = cfg.mode;
        pin_out = irq_active ? cfg.pol : ~cfg.pol;
    end

    // Power-down request from a low pad level while in input mode
    always_comb begin
        pdn_req = ~cfg.mode & ~sync_q[SYNC_STAGES-1];
    end

endmodule

// File: rtl/irq_pdn_pin_ctrl.sv
// Module: irq_pdn_pin_ctrl (top)
// Register decode, event banks and pad control for a pin shared between a
// power-down input and an interrupt output.
// Assumes: single-cycle register strobes; reads are combinational.
module irq_pdn_pin_ctrl
    import ipc_pkg::*;
#(
    parameter int unsigned SRC_PER_BANK = 8,
    parameter int unsigned NUM_BANKS    = 2,
    parameter int unsigned ADDR_W       = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic                              reg_wr_en,
    input  logic [2*SRC_PER_BANK-1:0]         reg_wr_data,
    input  logic                              reg_rd_en,
    output logic [2*SRC_PER_BANK-1:0]         reg_rd_data,
    input  logic [NUM_BANKS*SRC_PER_BANK-1:0] evt_pulse,
    input  logic                              pin_in,
    output logic                              pin_oe,
    output logic                              pin_out,
    output logic                              pdn_req
);

    localparam int unsigned DATA_W = 2 * SRC_PER_BANK;
    localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);

    ipc_cfg_t                cfg;
    logic                    cfg_wr;
    logic [NUM_BANKS-1:0]    bank_sel;
    logic [NUM_BANKS-1:0]    bank_hit;
    logic [SRC_PER_BANK-1:0] bank_en [NUM_BANKS];
    logic [SRC_PER_BANK-1:0] bank_st [NUM_BANKS];
    logic                    rd_clr;

    // Address decode for config and event banks
    always_comb begin
        cfg_wr = reg_wr_en && (reg_addr == CFG_A);
        for (int b = 0; b < NUM_BANKS; b++) begin
            bank_sel[b] = (reg_addr == ADDR_W'(BANK_BASE + b));
        end
        rd_clr = reg_rd_en && (|bank_sel);
    end

    ipc_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (cfg_wr),
        .wr_cfg (ipc_cfg_t'(reg_wr_data[CFG_W-1:0])),
        .cfg    (cfg)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        ipc_event_bank #(.NSRC(SRC_PER_BANK)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_sel     (reg_wr_en && bank_sel[g]),
            .wr_en_bits (reg_wr_data[SRC_PER_BANK-1:0]),
            .clr        (rd_clr),
            .evt        (evt_pulse[g*SRC_PER_BANK +: SRC_PER_BANK]),
            .en         (bank_en[g]),
            .st         (bank_st[g]),
            .hit        (bank_hit[g])
        );
    end

    ipc_pin_drive #(.SYNC_STAGES(2)) u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .any_hit (|bank_hit),
        .pin_in  (pin_in),
        .pin_oe  (pin_oe),
        .pin_out (pin_out),
        .pdn_req (pdn_req)
    );

    // Read multiplexer: status in the upper half, enables in the lower half
    always_comb begin
        reg_rd_data = '0;
        if (reg_addr == CFG_A) begin
            reg_rd_data = DATA_W'(cfg);
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_sel[b]) begin
                reg_rd_data = {bank_st[b], bank_en[b]};
            end
        end
    end

    AST_OE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pin_oe) || $fell(pin_oe)) |-> $past(cfg_wr)); // R2

endmodule

// File: tb/irq_pdn_pin_ctrl_test.sv
module irq_pdn_pin_ctrl_test;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr_en = 0;
    logic [15:0] reg_wr_data = '0;
    logic        reg_rd_en = 0;
    logic [15:0] reg_rd_data;
    logic [15:0] evt_pulse = '0;
    logic        pin_in = 1;
    logic        pin_oe, pin_out, pdn_req;

    int n_chk = 0;
    int n_fail = 0;

    // Behavioural model state
    logic [2:0] m_cfg;
    logic [7:0] m_en [2];
    logic [7:0] m_st [2];
    logic       m_s1, m_s2;

    always #10 clk = ~clk;

    irq_pdn_pin_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data),
        .evt_pulse(evt_pulse), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_out(pin_out), .pdn_req(pdn_req)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] m_rd(logic [4:0] a);
        case (a)
            5'h11:   return {13'd0, m_cfg};
            5'h12:   return {m_st[0], m_en[0]};
            5'h13:   return {m_st[1], m_en[1]};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic m_active(logic [15:0] ev);
        logic any = 1'b0;
        for (int b = 0; b < 2; b++)
            for (int k = 0; k < 8; k++)
                if (m_en[b][k] && (m_st[b][k] || ev[b*8+k])) any = 1'b1;
        return m_cfg[0] && m_cfg[1] && any;
    endfunction

    // One clock: compare outputs with the model, then advance the model
    task automatic cyc();
        logic clr;
        #2;
        if (rst_n) begin
            chk("R2 pin_oe", {15'd0, pin_oe}, {15'd0, m_cfg[0]});
            chk("R7/R9 pin_out", {15'd0, pin_out},
                {15'd0, m_active(evt_pulse) ? m_cfg[2] : ~m_cfg[2]});
            chk("R4 pdn_req", {15'd0, pdn_req}, {15'd0, ~m_cfg[0] & ~m_s2});
            chk("R10 rd_data", reg_rd_data, m_rd(reg_addr));
        end
        @(posedge clk);
        if (!rst_n) begin
            m_cfg = '0; m_en[0] = '0; m_en[1] = '0; m_st[0] = '0; m_st[1] = '0;
            m_s1 = 1'b1; m_s2 = 1'b1;
        end else begin
            clr = reg_rd_en && (reg_addr == 5'h12 || reg_addr == 5'h13);
            for (int b = 0; b < 2; b++)
                m_st[b] = (clr ? 8'h00 : m_st[b]) | evt_pulse[b*8 +: 8];
            if (reg_wr_en) begin
                if (reg_addr == 5'h11) m_cfg = reg_wr_data[2:0];
                if (reg_addr == 5'h12) m_en[0] = reg_wr_data[7:0];
                if (reg_addr == 5'h13) m_en[1] = reg_wr_data[7:0];
            end
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
        @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        reg_addr = a; reg_wr_data = d; reg_wr_en = 1; cyc(); reg_wr_en = 0;
    endtask

    task automatic rd_clear(logic [4:0] a);
        reg_addr = a; reg_rd_en = 1; cyc(); reg_rd_en = 0;
    endtask

    task automatic pulse(logic [15:0] ev);
        evt_pulse = ev; cyc(); evt_pulse = '0;
    endtask

    task automatic peek(logic [4:0] a, string tag, logic [15:0] exp);
        reg_addr = a; #1; chk(tag, reg_rd_data, exp);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        repeat (3) cyc();
        rst_n = 1;
        // R1 reset state
        peek(5'h11, "R1 cfg", 16'h0000);
        peek(5'h12, "R1 bank0", 16'h0000);
        peek(5'h13, "R1 bank1", 16'h0000);
        chk("R1 pin_oe", {15'd0, pin_oe}, 16'h0000);
        chk("R1 pdn_req", {15'd0, pdn_req}, 16'h0000);
        // R4 power-down request after two edges
        pin_in = 0; cyc();
        chk("R4 pdn one edge", {15'd0, pdn_req}, 16'h0000);
        cyc();
        chk("R4 pdn two edges", {15'd0, pdn_req}, 16'h0001);
        pin_in = 1; cyc(); cyc();
        // R3 config field width
        wr(5'h11, 16'hFFF8);
        peek(5'h11, "R3 upper bits dropped", 16'h0000);
        wr(5'h11, 16'h0006);
        peek(5'h11, "R3 readback", 16'h0006);
        peek(5'h14, "R3 unmapped", 16'h0000);
        chk("R2 input mode oe", {15'd0, pin_oe}, 16'h0000);
        // R6 enables only
        wr(5'h12, 16'hABCD);
        peek(5'h12, "R6 status ignores write", 16'h00CD);
        wr(5'h13, 16'h0001);
        peek(5'h13, "R6 bank1 enable", 16'h0001);
        // R5 event latching
        pulse(16'h0001);
        peek(5'h12, "R5 src0", 16'h01CD);
        pulse(16'h0200);
        peek(5'h13, "R5 src9", 16'h0201);
        // R10 / R11 clearing read with simultaneous event
        reg_addr = 5'h12; reg_rd_en = 1; evt_pulse = 16'h0100; #1;
        chk("R10 read returns content", reg_rd_data, 16'h01CD);
        cyc(); reg_rd_en = 0; evt_pulse = '0;
        peek(5'h12, "R10 bank0 cleared", 16'h00CD);
        peek(5'h13, "R11 event kept", 16'h0101);
        // R2 / R9 output mode, active-low
        wr(5'h11, 16'h0003);
        chk("R2 output mode oe", {15'd0, pin_oe}, 16'h0001);
        chk("R9 asserted low", {15'd0, pin_out}, 16'h0000);
        pin_in = 0; cyc(); cyc();
        chk("R4 no pdn in output mode", {15'd0, pdn_req}, 16'h0000);
        pin_in = 1;
        rd_clear(5'h13);
        chk("R9 idle high", {15'd0, pin_out}, 16'h0001);
        // R8 masked source
        evt_pulse = 16'h0002; #1;
        chk("R8 masked no drive", {15'd0, pin_out}, 16'h0001);
        cyc(); evt_pulse = '0;
        peek(5'h12, "R8 masked status set", 16'h02CD);
        chk("R8 masked still idle", {15'd0, pin_out}, 16'h0001);
        // R7 same-cycle assertion
        evt_pulse = 16'h0004; #1;
        chk("R7 same cycle", {15'd0, pin_out}, 16'h0000);
        cyc(); evt_pulse = '0; #1;
        chk("R7 held while pending", {15'd0, pin_out}, 16'h0000);
        // R9 active-high polarity
        wr(5'h11, 16'h0007);
        chk("R9 asserted high", {15'd0, pin_out}, 16'h0001);
        wr(5'h11, 16'h0005);
        chk("R8 irq disabled idle", {15'd0, pin_out}, 16'h0000);
        rd_clear(5'h12);
        // Pseudo-random traffic, compared every cycle against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            reg_addr    = 5'h11 + 5'(lfsr[1:0]);
            reg_wr_en   = (lfsr[6:4] == 3'd0);
            reg_rd_en   = (lfsr[9:7] == 3'd1);
            reg_wr_data = {lfsr[7:0], lfsr[15:8]};
            evt_pulse   = (lfsr[12:10] == 3'd2) ? (16'h1 << lfsr[15:12]) : 16'h0;
            if (lfsr[14:13] == 2'b11) pin_in = ~pin_in;
            cyc();
        end
        reg_wr_en = 0; reg_rd_en = 0; evt_pulse = '0;
        cyc();
        summary();
        $finish;
    end

endmodule